// File: doc/BRIEF.md
# Adaptive Next-Line Prefetcher

This block sits beside a last-level cache and suggests the sequential next line whenever a demand access misses. It also decides whether that suggestion is worth making. Each issued prefetch is remembered in a small first-in first-out sampler, along with a short tag derived from the program counter of the triggering load. A later demand access that lands on a remembered line is proof that the prefetch helped. A remembered line that is evicted, or pushed out of the sampler before any access reaches it, counts as waste.

Helpful and wasted counts are kept twice: once in a single pair of global counters and once in a table indexed by the folded program counter. A miss produces a prefetch only if neither the global pair nor the table entry for its program counter shows more than four wasted prefetches for each helpful one. Every so often, after a fixed number of demand accesses, all counts are halved. Old behaviour therefore fades out, and a throttled source can come back after a change of program phase.

The cache array, its miss handling and the issue queue toward memory are outside this block. The block takes one demand access and one eviction notice per cycle and produces at most one prefetch per cycle.

Top module: `anl_prefetcher`

## Requirements
- R1: When a demand access with the miss flag set is accepted and the throttle is open, pf_valid is high on the next cycle and pf_line equals the access line plus one, wrapping modulo 2^LINE_W. A demand hit or an idle cycle produces no prefetch on the next cycle.
- R2: An issued prefetch is written into the sampler at the write pointer, together with the slot of its program counter, and the pointer then advances. If the prefetched line is already held in the sampler, the prefetch is still issued but no second entry is written.
- R3: A demand access, hit or miss, whose line matches a held sampler entry adds one to the global helpful count and one to the helpful count of that entry's slot. It then removes the entry, so a repeated access to the same line adds nothing more.
- R4: An eviction notice whose line matches a held sampler entry adds one wasted count, globally and to that entry's slot, and removes the entry. If a demand access hits the same entry in the same cycle, only the helpful count is taken.
- R5: The sampler has 32 entries and replaces them first-in first-out. A push that overwrites an entry which is still held counts that entry as wasted, globally and for its slot.
- R6: The slot of a program counter is the XOR of its bits in 5-bit groups starting at bit 0 (pc[4:0] ^ pc[9:5] ^ pc[14:10] ^ pc[15] for a 16-bit PC). Each of the 32 slots holds a 6-bit saturating helpful count and a 6-bit saturating wasted count, and these counts affect only misses that map to that slot.
- R7: The global helpful and wasted counts are 16-bit saturating counters. An eviction match and a sampler overwrite in the same cycle add two to the wasted count.
- R8: A miss is suppressed when helpful×4 < wasted holds for the global pair or for the slot of its program counter. The test uses the counts held before the current cycle's updates.
- R9: On every 2^DECAY_LOG-th accepted demand access (4096 by default), all global and per-slot counts are halved after that cycle's increments have been applied.
- R10: While reset is held and on the first cycle after it, pf_valid is low. Reset clears the sampler and every count, so all misses issue prefetches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_miss | input | 1 | The demand access missed in the cache |
| acc_pc | input | PC_W | Program counter of the demand access |
| acc_line | input | LINE_W | Line address of the demand access |
| evict_valid | input | 1 | A line leaves the cache this cycle |
| evict_line | input | LINE_W | Line address being evicted |
| pf_valid | output | 1 | Prefetch request valid |
| pf_line | output | LINE_W | Line address to prefetch |

## Verification
Internal state can only be seen through throttling. A wrong count, a sampler entry that is not cleared, or a wrong slot index has no visible effect until it moves a ratio across the threshold. It then shows up one cycle after some later miss, as a missing or extra pf_valid. That can be hundreds of cycles after the fault. For this reason the bench keeps its own model of the sampler and all counters and compares pf_valid and pf_line on every cycle. It also drives long stretches that deliberately push the global pair and single slots into and out of suppression. Decay faults appear only at the 2^DECAY_LOG boundary, so the bench uses a short decay period to cross that boundary many times.

// File: rtl/anl_pkg.sv
package anl_pkg;

  // Saturating add on a 32-bit carrier; callers truncate to their width.
  function automatic logic [31:0] sat_add(logic [31:0] cur, logic [31:0] inc,
                                          logic [31:0] maxv);
    logic [32:0] sum;
    sum = {1'b0, cur} + {1'b0, inc};
    return (sum > {1'b0, maxv}) ? maxv : sum[31:0];
  endfunction

  // Throttle test without a divider: helpful*4 below wasted.
  function automatic logic ratio_low(logic [31:0] helpful, logic [31:0] wasted);
    logic [33:0] scaled;
    scaled = {helpful, 2'b00};
    return scaled < {2'b00, wasted};
  endfunction

endpackage

// File: rtl/anl_sampler.sv
module anl_sampler #(
  parameter int DEPTH  = 32,
  parameter int LINE_W = 26,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [LINE_W-1:0] acc_line,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  input  logic [LINE_W-1:0] query_line,
  output logic              query_hit,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  output logic              useful_evt,
  output logic [IDX_W-1:0]  useful_idx,
  output logic              evict_evt,
  output logic [IDX_W-1:0]  evict_idx,
  output logic              ovf_evt,
  output logic [IDX_W-1:0]  ovf_idx
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [IDX_W-1:0]  idx_q  [DEPTH];
  logic [AW-1:0]     wptr_q;

  logic [DEPTH-1:0] hit_vec, ev_vec, q_vec;

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      hit_vec[e] = acc_valid && vld_q[e] && (line_q[e] == acc_line);
      ev_vec[e]  = evict_valid && vld_q[e] && (line_q[e] == evict_line) && !hit_vec[e];
      q_vec[e]   = vld_q[e] && (line_q[e] == query_line);
    end
  end

  always_comb begin
    useful_idx = '0;
    evict_idx  = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (hit_vec[e]) useful_idx = idx_q[e];
      if (ev_vec[e])  evict_idx  = idx_q[e];
    end
  end

  assign query_hit  = |q_vec;
  assign useful_evt = |hit_vec;
  assign evict_evt  = |ev_vec;
  assign ovf_evt    = push && vld_q[wptr_q] && !hit_vec[wptr_q] && !ev_vec[wptr_q];
  assign ovf_idx    = idx_q[wptr_q];

  always_comb begin
    vld_d = vld_q & ~hit_vec & ~ev_vec;
    if (push) vld_d[wptr_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      wptr_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        line_q[e] <= '0;
        idx_q[e]  <= '0;
      end
    end else begin
      vld_q <= vld_d;
      if (push) begin
        line_q[wptr_q] <= query_line;
        idx_q[wptr_q]  <= push_idx;
        wptr_q         <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
      end
    end
  end

  // R3
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R4
  evict_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_vec));

  // R2
  push_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> vld_q[$past(wptr_q)]);

endmodule

// File: rtl/anl_pc_table.sv
module anl_pc_table
  import anl_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  input  logic             useful_evt,
  input  logic [IDX_W-1:0] useful_idx,
  input  logic             waste_a_evt,
  input  logic [IDX_W-1:0] waste_a_idx,
  input  logic             waste_b_evt,
  input  logic [IDX_W-1:0] waste_b_idx,
  input  logic             decay_evt,
  output logic             throttle
);
  localparam int          ENTRIES = 1 << IDX_W;
  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0] use_q   [ENTRIES];
  logic [CNT_W-1:0] waste_q [ENTRIES];
  logic [CNT_W-1:0] use_d   [ENTRIES];
  logic [CNT_W-1:0] waste_d [ENTRIES];

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      use_d[e] = CNT_W'(sat_add(32'(use_q[e]),
                 (useful_evt && useful_idx == IDX_W'(e)) ? 32'd1 : 32'd0, CNT_MAX));
      waste_d[e] = CNT_W'(sat_add(32'(waste_q[e]),
                 ((waste_a_evt && waste_a_idx == IDX_W'(e)) ? 32'd1 : 32'd0) +
                 ((waste_b_evt && waste_b_idx == IDX_W'(e)) ? 32'd1 : 32'd0), CNT_MAX));
      if (decay_evt) begin
        use_d[e]   = use_d[e] >> 1;
        waste_d[e] = waste_d[e] >> 1;
      end
    end
  end

  assign throttle = ratio_low(32'(use_q[look_idx]), 32'(waste_q[look_idx]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        use_q[e]   <= '0;
        waste_q[e] <= '0;
      end
    end else begin
      use_q   <= use_d;
      waste_q <= waste_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R6
    slot_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !decay_evt |=> (use_q[g] >= $past(use_q[g])) && (waste_q[g] >= $past(waste_q[g])));
  end

endmodule

// File: rtl/anl_global_meter.sv
module anl_global_meter
  import anl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DECAY_LOG = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic useful_evt,
  input  logic waste_a_evt,
  input  logic waste_b_evt,
  output logic decay_evt,
  output logic throttle
);
  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0]     useful_q, waste_q, useful_d, waste_d;
  logic [DECAY_LOG-1:0] tick_q;
  logic [31:0]          waste_inc;

  assign waste_inc = (waste_a_evt ? 32'd1 : 32'd0) + (waste_b_evt ? 32'd1 : 32'd0);
  assign decay_evt = acc_valid && (&tick_q);

  always_comb begin
    useful_d = CNT_W'(sat_add(32'(useful_q), useful_evt ? 32'd1 : 32'd0, CNT_MAX));
    waste_d  = CNT_W'(sat_add(32'(waste_q), waste_inc, CNT_MAX));
    if (decay_evt) begin
      useful_d = useful_d >> 1;
      waste_d  = waste_d >> 1;
    end
  end

  assign throttle = ratio_low(32'(useful_q), 32'(waste_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      useful_q <= '0;
      waste_q  <= '0;
      tick_q   <= '0;
    end else begin
      useful_q <= useful_d;
      waste_q  <= waste_d;
      if (acc_valid) tick_q <= tick_q + DECAY_LOG'(1);
    end
  end

  // R7
  global_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !decay_evt |=> (useful_q >= $past(useful_q)) && (waste_q >= $past(waste_q)));

  // R9
  decay_halve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decay_evt |=> useful_q <= ($past(useful_q) >> 1) + CNT_W'(1));

endmodule

// File: rtl/anl_prefetcher.sv
module anl_prefetcher
  import anl_pkg::*;
#(
  parameter int LINE_W     = 26,
  parameter int PC_W       = 16,
  parameter int SAMP_DEPTH = 32,
  parameter int IDX_W      = 5,
  parameter int SLOT_CNT_W = 6,
  parameter int GLOB_CNT_W = 16,
  parameter int DECAY_LOG  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_miss,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [LINE_W-1:0] acc_line,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line
);

  function automatic logic [IDX_W-1:0] fold_pc(logic [PC_W-1:0] pc);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < PC_W; i++) h[i % IDX_W] = h[i % IDX_W] ^ pc[i];
    return h;
  endfunction

  logic [IDX_W-1:0]  slot;
  logic [LINE_W-1:0] next_line;
  logic              g_low, p_low, issue, push, query_hit, decay_evt;
  logic              useful_evt, evict_evt, ovf_evt;
  logic [IDX_W-1:0]  useful_idx, evict_idx, ovf_idx;

  assign slot      = fold_pc(acc_pc);
  assign next_line = acc_line + LINE_W'(1);
  assign issue     = acc_valid && acc_miss && !g_low && !p_low;
  assign push      = issue && !query_hit;

  anl_sampler #(.DEPTH(SAMP_DEPTH), .LINE_W(LINE_W), .IDX_W(IDX_W)) samp_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_line(acc_line),
    .evict_valid(evict_valid), .evict_line(evict_line),
    .query_line(next_line), .query_hit(query_hit),
    .push(push), .push_idx(slot),
    .useful_evt(useful_evt), .useful_idx(useful_idx),
    .evict_evt(evict_evt), .evict_idx(evict_idx),
    .ovf_evt(ovf_evt), .ovf_idx(ovf_idx)
  );

  anl_pc_table #(.IDX_W(IDX_W), .CNT_W(SLOT_CNT_W)) slots_i (
    .clk(clk), .rst_n(rst_n), .look_idx(slot),
    .useful_evt(useful_evt), .useful_idx(useful_idx),
    .waste_a_evt(evict_evt), .waste_a_idx(evict_idx),
    .waste_b_evt(ovf_evt), .waste_b_idx(ovf_idx),
    .decay_evt(decay_evt), .throttle(p_low)
  );

  anl_global_meter #(.CNT_W(GLOB_CNT_W), .DECAY_LOG(DECAY_LOG)) glob_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .useful_evt(useful_evt), .waste_a_evt(evict_evt), .waste_b_evt(ovf_evt),
    .decay_evt(decay_evt), .throttle(g_low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_line  <= '0;
    end else begin
      pf_valid <= issue;
      pf_line  <= next_line;
    end
  end

  // R1
  pf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(acc_valid && acc_miss));

  // R1
  pf_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_line == $past(acc_line) + LINE_W'(1));

  // R1
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_miss |=> !pf_valid);

  // R8
  throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_miss && (g_low || p_low) |=> !pf_valid);

endmodule

// File: tb/anl_prefetcher_tb_top.sv
module anl_prefetcher_tb_top;
  localparam int LW = 26;
  localparam int PW = 16;
  localparam int DEPTH = 32;
  localparam int DLOG = 7;
  localparam int NSLOT = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, acc_valid, acc_miss, evict_valid;
  logic [PW-1:0] acc_pc;
  logic [LW-1:0] acc_line, evict_line;
  logic          pf_valid;
  logic [LW-1:0] pf_line;

  anl_prefetcher #(.LINE_W(LW), .PC_W(PW), .DECAY_LOG(DLOG)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_miss(acc_miss),
    .acc_pc(acc_pc), .acc_line(acc_line), .evict_valid(evict_valid),
    .evict_line(evict_line), .pf_valid(pf_valid), .pf_line(pf_line)
  );

  int vecs = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model
  bit            mv [DEPTH];
  logic [LW-1:0] ml [DEPTH];
  int            ms [DEPTH];
  int            mwp, gu, gw, ticks;
  int            su [NSLOT];
  int            sw [NSLOT];

  function automatic int pc_slot(logic [PW-1:0] pc);
    int v;
    v = int'(pc);
    return (v ^ (v >> 5) ^ (v >> 10) ^ (v >> 15)) & 31;
  endfunction

  function automatic int bump(int v, int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  task automatic model_clear();
    for (int e = 0; e < DEPTH; e++) begin mv[e] = 0; ml[e] = '0; ms[e] = 0; end
    for (int s = 0; s < NSLOT; s++) begin su[s] = 0; sw[s] = 0; end
    mwp = 0; gu = 0; gw = 0; ticks = 0;
  endtask

  task automatic step(input bit av, input bit am, input logic [PW-1:0] pc,
                      input logic [LW-1:0] ln, input bit ev, input logic [LW-1:0] el,
                      input string tag);
    int hj, ek, s;
    bit exp_v, dup;
    logic [LW-1:0] exp_l;
    acc_valid = av; acc_miss = am; acc_pc = pc; acc_line = ln;
    evict_valid = ev; evict_line = el;
    s = pc_slot(pc);
    exp_l = ln + 1'b1;
    exp_v = av && am && !(gu * 4 < gw) && !(su[s] * 4 < sw[s]);
    hj = -1; ek = -1; dup = 0;
    for (int e = 0; e < DEPTH; e++) if (av && mv[e] && ml[e] == ln) hj = e;
    for (int e = 0; e < DEPTH; e++) if (ev && mv[e] && ml[e] == el && e != hj) ek = e;
    for (int e = 0; e < DEPTH; e++) if (mv[e] && ml[e] == exp_l) dup = 1;
    if (hj >= 0) begin gu = bump(gu, 65535); su[ms[hj]] = bump(su[ms[hj]], 63); mv[hj] = 0; end
    if (ek >= 0) begin gw = bump(gw, 65535); sw[ms[ek]] = bump(sw[ms[ek]], 63); mv[ek] = 0; end
    if (exp_v && !dup) begin
      if (mv[mwp]) begin gw = bump(gw, 65535); sw[ms[mwp]] = bump(sw[ms[mwp]], 63); end
      mv[mwp] = 1; ml[mwp] = exp_l; ms[mwp] = s; mwp = (mwp + 1) % DEPTH;
    end
    if (av) begin
      if (ticks == (1 << DLOG) - 1) begin
        ticks = 0; gu = gu / 2; gw = gw / 2;
        for (int k = 0; k < NSLOT; k++) begin su[k] = su[k] / 2; sw[k] = sw[k] / 2; end
      end else ticks = ticks + 1;
    end
    @(posedge clk);
    @(negedge clk);
    vecs++;
    if (pf_valid !== exp_v || (exp_v && pf_line !== exp_l)) begin
      bad++;
      $display("FAIL %s: actual valid=%0b line=%0h, expected valid=%0b line=%0h",
               tag, pf_valid, pf_line, exp_v, exp_l);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, '0, 0, '0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    acc_valid = 0; acc_miss = 0; acc_pc = '0; acc_line = '0;
    evict_valid = 0; evict_line = '0;
    repeat (3) @(negedge clk);
    // R10: output low while reset is held
    vecs++;
    if (pf_valid !== 1'b0) begin
      bad++;
      $display("FAIL R10: actual valid=%0b during reset, expected 0", pf_valid);
    end
    rst_n = 1'b1;
    model_clear();
  endtask

  localparam logic [PW-1:0] PC_B = 16'h0040;
  localparam logic [PW-1:0] PC_A = 16'h0080;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (R1..): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10: first cycles after reset are quiet
    idle("R10");
    idle("R10");

    // R1: sequential misses on one PC
    for (int k = 0; k < 8; k++) step(1, 1, PC_B, LW'(100 + k), 0, '0, "R1");
    // R1: line wrap at the top of the address space
    step(1, 1, PC_B, '1, 0, '0, "R1");
    // R1: hits never prefetch
    step(1, 0, PC_B, LW'(77), 0, '0, "R1");

    // R3: hit prefetched lines, then hit again (no second credit)
    for (int k = 0; k < 8; k++) step(1, 0, PC_B, LW'(101 + k), 0, '0, "R3");
    for (int k = 0; k < 4; k++) step(1, 0, PC_B, LW'(101 + k), 0, '0, "R3");

    // R2: duplicate prefetch target is issued but recorded once
    step(1, 1, PC_B, LW'(500), 0, '0, "R2");
    step(1, 1, PC_B, LW'(500), 0, '0, "R2");
    step(1, 0, PC_B, LW'(501), 0, '0, "R2");
    step(1, 0, PC_B, LW'(501), 0, '0, "R2");

    // R4: evictions of unused prefetches waste one slot
    for (int k = 0; k < 10; k++) step(1, 1, PC_A, LW'(200 + 2 * k), 0, '0, "R4");
    for (int k = 0; k < 10; k++) step(0, 0, '0, '0, 1, LW'(201 + 2 * k), "R4");
    // R8: that slot is throttled, another still issues
    step(1, 1, PC_A, LW'(300), 0, '0, "R8");
    step(1, 1, PC_B, LW'(302), 0, '0, "R8");
    // R4: hit and eviction of the same line in one cycle
    step(1, 1, PC_B, LW'(400), 0, '0, "R4");
    step(1, 0, PC_B, LW'(401), 1, LW'(401), "R4");
    step(1, 1, PC_B, LW'(410), 0, '0, "R4");

    // R5: many sources overflow the sampler and trip the global throttle
    for (int k = 0; k < 90; k++) step(1, 1, PW'(16'h1000 + 4 * k), LW'(2000 + 2 * k), 0, '0, "R5");
    step(1, 1, PC_B, LW'(3000), 0, '0, "R8");

    // R9: decay lets throttled sources recover
    for (int k = 0; k < 700; k++) step(1, 0, PC_B, LW'(9000 + k), 0, '0, "R9");
    step(1, 1, PC_A, LW'(4000), 0, '0, "R9");
    step(1, 1, PC_B, LW'(4100), 0, '0, "R9");

    // R6: PCs spread over the slots, with mixed outcomes
    for (int k = 0; k < 64; k++) begin
      step(1, 1, PW'(k * 37), LW'(6000 + 4 * k), 0, '0, "R6");
      if (k % 3 == 0) step(0, 0, '0, '0, 1, LW'(6001 + 4 * k), "R6");
      else if (k % 3 == 1) step(1, 0, PW'(k * 37), LW'(6001 + 4 * k), 0, '0, "R6");
    end

    // R10: reset in the middle reopens every source
    do_reset();
    idle("R10");
    step(1, 1, PC_A, LW'(50), 0, '0, "R10");

    // R7: random mix with simultaneous evictions and overflows
    for (int n = 0; n < 20000; n++) begin
      logic [PW-1:0] pc;
      case ($urandom % 4)
        0: pc = PC_A;
        1: pc = PC_B;
        2: pc = 16'h1234;
        default: pc = 16'h0ff0;
      endcase
      step(($urandom % 4) != 0, ($urandom % 2) == 1, pc, LW'($urandom % 48),
           ($urandom % 3) == 0, LW'($urandom % 48), "R7");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule